// File: doc/BRIEF.md
# PWM Compare Shadow Load Controller

This block holds the two counter-compare values (channel A and channel B) that a PWM action stage compares against its time-base counter. Each channel keeps a CPU-writable shadow word and an active word. Each word is a compare field with a high-resolution extension below it. The active word is what the outputs present. A 16-bit control register sets three things per channel: whether writes land in the shadow or go straight to the active word, which counter event copies shadow to active, and whether an external sync pulse also triggers that copy.

The register port is one address bus with two write strobes. `wr_cmp_i` writes the compare field and `wr_hr_i` writes the extension field. A full flag per channel shows that a shadow value is waiting for transfer. A link bit can make the B extension output follow the A extension, which suits complementary outputs. The time-base counter supplies single-cycle strobes for counter-equals-zero and counter-equals-period.

Top module: `cmp_shadow_load`

## Requirements
- R1: After reset the control register reads 0, both active words are 0 and both full flags are 0.
- R2: With the channel mode bit set to 1 (immediate), a write reaches the active word at the next clock edge. The full flag stays 0 and counter or sync strobes leave the active word unchanged.
- R3: In shadow mode with sync-load field 00, load-mode field 00 copies on zero, 01 on period, 10 on either, and 11 never copies.
- R4: In shadow mode, sync-load field 01 copies on the load-mode event or on sync. Field 10 copies on sync only. Field 11 behaves as 00.
- R5: In shadow mode a write with `wr_cmp_i` sets the full flag. A write with only `wr_hr_i` updates the shadow extension and leaves the flag unchanged.
- R6: A shadow-to-active copy clears the full flag. A second write before the copy replaces the pending value, so only the last value is transferred.
- R7: When a compare write and a copy happen in the same cycle, the active word takes the old shadow and the full flag ends at 1.
- R8: The compare field and the extension field move from shadow to active in the same clock edge.
- R9: With control bit 15 at 1, `hrb_o` shows the A active extension. With bit 15 at 0 it shows the B active extension. `cmpb_o` is unaffected by this bit.
- R10: The control register is laid out as follows. Bit 15 is link. Bits 13:12 are B sync-load and bits 11:10 are A sync-load. Bit 9 is the B full flag and bit 8 is the A full flag; both are read-only. Bit 6 is the B mode and bit 4 is the A mode. Bits 3:2 are the B load mode and bits 1:0 are the A load mode. The remaining bits read 0. The register is written at address 0 with `wr_cmp_i`.
- R11: Address 1 selects channel A and address 2 selects channel B. A read in shadow mode returns the shadow word. A read in immediate mode returns the active word. Both are given as {compare, extension}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 control, 1 channel A, 2 channel B |
| wr_cmp_i | input | 1 | Write strobe for the compare field, or the control register at address 0 |
| wr_hr_i | input | 1 | Write strobe for the high-resolution extension field |
| wdata_i | input | CMP_W+HR_W | Write data as {compare, extension} |
| rd_data_o | output | CMP_W+HR_W | Combinational read data for `addr_i` |
| ctr_zero_i | input | 1 | Strobe when the counter equals zero |
| ctr_prd_i | input | 1 | Strobe when the counter equals period |
| sync_i | input | 1 | External sync pulse |
| cmpa_o | output | CMP_W | Active compare A |
| hra_o | output | HR_W | Active extension A |
| cmpb_o | output | CMP_W | Active compare B |
| hrb_o | output | HR_W | Extension B, or A when linked |
| full_o | output | 2 | Shadow full flags, bit 0 for A and bit 1 for B |

## Verification
The assertions check several rules on every cycle:
- the flag is set by a compare write and cleared by a copy;
- the flag never rises without a compare write;
- the active word never moves while frozen;
- no copy happens without sync in sync-only mode;
- every copy moves the whole shadow word at once.

Some behaviours can only be shown by the bench's scenarios. These are the full decode of every load-mode and sync-load pair against each single event, the control readback layout, the link multiplexing, the extension-only write, and the ordering when a write and a copy collide. The bench sweeps both channels through every mode, load field, sync field and event.

// File: rtl/cmp_pkg.sv
`timescale 1ns/1ps
package cmp_pkg;
  localparam int NCH    = 2;
  localparam int CTRL_W = 16;
  localparam logic [1:0] ADDR_CTRL = 2'd0;

  typedef enum logic [1:0] {LD_ZERO = 2'd0, LD_PRD = 2'd1, LD_BOTH = 2'd2, LD_FREEZE = 2'd3} ld_mode_e;
  typedef enum logic [1:0] {SY_OFF = 2'd0, SY_ALSO = 2'd1, SY_ONLY = 2'd2, SY_RSVD = 2'd3} sy_mode_e;

  typedef struct packed {
    logic     imm;
    ld_mode_e ld;
    sy_mode_e sy;
  } chan_cfg_t;

  function automatic logic load_hit(chan_cfg_t c, logic zero, logic prd, logic sync);
    logic ev;
    case (c.ld)
      LD_ZERO: ev = zero;
      LD_PRD:  ev = prd;
      LD_BOTH: ev = zero | prd;
      default: ev = 1'b0;
    endcase
    if (c.imm) return 1'b0;
    case (c.sy)
      SY_ALSO: return ev | sync;
      SY_ONLY: return sync;
      default: return ev;  // reserved code acts as event-only
    endcase
  endfunction
endpackage

// File: rtl/cmp_ctrl_reg.sv
`timescale 1ns/1ps
module cmp_ctrl_reg
  import cmp_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [CTRL_W-1:0]        wdata_i,
  output chan_cfg_t [NCH-1:0]      cfg_o,
  output logic                     link_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_o <= 1'b0;
      cfg_o  <= '0;
    end else if (we_i) begin
      link_o     <= wdata_i[15];
      cfg_o[1].sy  <= sy_mode_e'(wdata_i[13:12]);
      cfg_o[0].sy  <= sy_mode_e'(wdata_i[11:10]);
      cfg_o[1].imm <= wdata_i[6];
      cfg_o[0].imm <= wdata_i[4];
      cfg_o[1].ld  <= ld_mode_e'(wdata_i[3:2]);
      cfg_o[0].ld  <= ld_mode_e'(wdata_i[1:0]);
    end
  end
endmodule

// File: rtl/cmp_load_sel.sv
`timescale 1ns/1ps
module cmp_load_sel
  import cmp_pkg::*;
(
  input  chan_cfg_t [NCH-1:0] cfg_i,
  input  logic                zero_i,
  input  logic                prd_i,
  input  logic                sync_i,
  output logic [NCH-1:0]      load_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign load_o[k] = load_hit(cfg_i[k], zero_i, prd_i, sync_i);
  end
endmodule

// File: rtl/cmp_channel.sv
`timescale 1ns/1ps
module cmp_channel #(
  parameter int CMP_W = 16,
  parameter int HR_W  = 8,
  localparam int DW   = CMP_W + HR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          imm_i,
  input  logic          load_i,
  input  logic          wr_cmp_i,
  input  logic          wr_hr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] active_o,
  output logic [DW-1:0] shadow_o,
  output logic          full_o
);
  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d,
                                          logic wc, logic wh);
    logic [DW-1:0] r;
    r = old;
    if (wc) r[DW-1:HR_W] = d[DW-1:HR_W];
    if (wh) r[HR_W-1:0]  = d[HR_W-1:0];
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= '0;
      shadow_o <= '0;
      full_o   <= 1'b0;
    end else if (imm_i) begin
      active_o <= merge(active_o, wdata_i, wr_cmp_i, wr_hr_i);
      full_o   <= 1'b0;
    end else begin
      if (load_i) active_o <= shadow_o;  // old shadow wins on collision
      shadow_o <= merge(shadow_o, wdata_i, wr_cmp_i, wr_hr_i);
      if (wr_cmp_i)    full_o <= 1'b1;
      else if (load_i) full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cmp_shadow_load.sv
`timescale 1ns/1ps
module cmp_shadow_load
  import cmp_pkg::*;
#(
  parameter int CMP_W = 16,
  parameter int HR_W  = 8,
  localparam int DW   = CMP_W + HR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_cmp_i,
  input  logic              wr_hr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic              ctr_zero_i,
  input  logic              ctr_prd_i,
  input  logic              sync_i,
  output logic [CMP_W-1:0]  cmpa_o,
  output logic [HR_W-1:0]   hra_o,
  output logic [CMP_W-1:0]  cmpb_o,
  output logic [HR_W-1:0]   hrb_o,
  output logic [NCH-1:0]    full_o
);
  chan_cfg_t [NCH-1:0]      cfg_w;
  logic                     link_w;
  logic [NCH-1:0]           load_w;
  logic [NCH-1:0]           wc_w;
  logic [NCH-1:0]           wh_w;
  logic [NCH-1:0][DW-1:0]   act_w;
  logic [NCH-1:0][DW-1:0]   shd_w;
  logic [CTRL_W-1:0]        ctrl_rd;

  cmp_ctrl_reg i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_cmp_i && addr_i == ADDR_CTRL),
    .wdata_i (wdata_i[CTRL_W-1:0]),
    .cfg_o   (cfg_w),
    .link_o  (link_w)
  );

  cmp_load_sel i_sel (
    .cfg_i  (cfg_w),
    .zero_i (ctr_zero_i),
    .prd_i  (ctr_prd_i),
    .sync_i (sync_i),
    .load_o (load_w)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign wc_w[k] = wr_cmp_i && addr_i == 2'(k + 1);
    assign wh_w[k] = wr_hr_i  && addr_i == 2'(k + 1);
    cmp_channel #(.CMP_W(CMP_W), .HR_W(HR_W)) i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .imm_i    (cfg_w[k].imm),
      .load_i   (load_w[k]),
      .wr_cmp_i (wc_w[k]),
      .wr_hr_i  (wh_w[k]),
      .wdata_i  (wdata_i),
      .active_o (act_w[k]),
      .shadow_o (shd_w[k]),
      .full_o   (full_o[k])
    );
  end

  assign ctrl_rd = {link_w, 1'b0, cfg_w[1].sy, cfg_w[0].sy, full_o[1], full_o[0],
                    1'b0, cfg_w[1].imm, 1'b0, cfg_w[0].imm, cfg_w[1].ld, cfg_w[0].ld};

  always_comb begin
    case (addr_i)
      2'd0:    rd_data_o = {{(DW-CTRL_W){1'b0}}, ctrl_rd};
      2'd1:    rd_data_o = cfg_w[0].imm ? act_w[0] : shd_w[0];
      2'd2:    rd_data_o = cfg_w[1].imm ? act_w[1] : shd_w[1];
      default: rd_data_o = '0;
    endcase
  end

  assign cmpa_o = act_w[0][DW-1:HR_W];
  assign hra_o  = act_w[0][HR_W-1:0];
  assign cmpb_o = act_w[1][DW-1:HR_W];
  assign hrb_o  = link_w ? act_w[0][HR_W-1:0] : act_w[1][HR_W-1:0];
endmodule

// File: rtl/cmp_shadow_chk.sv
`timescale 1ns/1ps
module cmp_shadow_chk
  import cmp_pkg::*;
#(
  parameter int DW = 24
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input chan_cfg_t [NCH-1:0]    cfg,
  input logic [NCH-1:0]         load,
  input logic [NCH-1:0]         wc,
  input logic [NCH-1:0][DW-1:0] act,
  input logic [NCH-1:0][DW-1:0] shd,
  input logic [NCH-1:0]         full,
  input logic                   sync_i
);
  for (genvar k = 0; k < NCH; k++) begin : g_a
    a_r2_imm_flag_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg[k].imm && $past(cfg[k].imm) |-> !full[k]);
    a_r3_freeze_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg[k].imm && cfg[k].ld == LD_FREEZE && (cfg[k].sy == SY_OFF || cfg[k].sy == SY_RSVD)
      |=> $stable(act[k]));
    a_r4_sync_only_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg[k].imm && cfg[k].sy == SY_ONLY && !sync_i |-> !load[k]);
    a_r5_write_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg[k].imm && wc[k] |=> full[k]);
    a_r5_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !full[k] && !wc[k] |=> !full[k]);
    a_r6_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load[k] && !wc[k] |=> !full[k]);
    a_r8_joint_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load[k] |=> act[k] == $past(shd[k]));
  end
endmodule

bind cmp_shadow_load cmp_shadow_chk #(.DW(DW)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cfg    (cfg_w),
  .load   (load_w),
  .wc     (wc_w),
  .act    (act_w),
  .shd    (shd_w),
  .full   (full_o),
  .sync_i (sync_i)
);

// File: tb/test_cmp_shadow_load.sv
`timescale 1ns/1ps
module test_cmp_shadow_load;
  localparam int CMP_W = 16;
  localparam int HR_W  = 8;
  localparam int DW    = CMP_W + HR_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic wr_cmp_i = 1'b0, wr_hr_i = 1'b0;
  logic [DW-1:0] wdata_i = '0, rd_data_o;
  logic ctr_zero_i = 1'b0, ctr_prd_i = 1'b0, sync_i = 1'b0;
  logic [CMP_W-1:0] cmpa_o, cmpb_o;
  logic [HR_W-1:0] hra_o, hrb_o;
  logic [1:0] full_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_shadow_load #(.CMP_W(CMP_W), .HR_W(HR_W)) i_cmp_shadow_load (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wr_cmp_i(wr_cmp_i), .wr_hr_i(wr_hr_i),
    .wdata_i(wdata_i), .rd_data_o(rd_data_o), .ctr_zero_i(ctr_zero_i), .ctr_prd_i(ctr_prd_i),
    .sync_i(sync_i), .cmpa_o(cmpa_o), .hra_o(hra_o), .cmpb_o(cmpb_o), .hrb_o(hrb_o),
    .full_o(full_o));

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one cycle of stimulus applied at a falling edge, removed at the next one
  task automatic cyc(logic [1:0] a, logic wc, logic wh, logic [DW-1:0] d,
                     logic z, logic p, logic s);
    @(negedge clk);
    addr_i = a; wr_cmp_i = wc; wr_hr_i = wh; wdata_i = d;
    ctr_zero_i = z; ctr_prd_i = p; sync_i = s;
    @(negedge clk);
    wr_cmp_i = 1'b0; wr_hr_i = 1'b0; ctr_zero_i = 1'b0; ctr_prd_i = 1'b0; sync_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [DW-1:0] v);
    addr_i = a; #1; v = rd_data_o;
  endtask

  function automatic logic [DW-1:0] act_of(int ch);
    return ch == 0 ? {cmpa_o, hra_o} : {cmpb_o, hrb_o};
  endfunction

  function automatic logic exp_hit(int ld, int sy, int ev);
    logic e, s;
    e = (ld == 0) ? (ev == 0) : (ld == 1) ? (ev == 1) : (ld == 2) ? (ev < 2) : 1'b0;
    s = (ev == 2);
    return (sy == 1) ? (e | s) : (sy == 2) ? s : e;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, exp_act[2], wv;
    int n;
    n = 0;
    exp_act[0] = '0; exp_act[1] = '0;
    #12 rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, '0);
    check("R1 act A", act_of(0), '0);
    check("R1 act B", act_of(1), '0);
    check("R1 full", {22'd0, full_o}, '0);

    // R10 layout: all ones, flags read-only and clear
    cyc(2'd0, 1'b1, 1'b0, 24'hFFFFFF, 1'b0, 1'b0, 1'b0);
    rd(2'd0, v); check("R10 ctrl readback", v, 24'h00BC5F);
    cyc(2'd0, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    rd(2'd0, v); check("R10 ctrl cleared", v, '0);

    // sweep: channel x mode x load field x sync field x event
    for (int ch = 0; ch < 2; ch++)
      for (int imm = 0; imm < 2; imm++)
        for (int ld = 0; ld < 4; ld++)
          for (int sy = 0; sy < 4; sy++)
            for (int ev = 0; ev < 3; ev++) begin
              logic [15:0] c;
              logic hit;
              c = (ch == 0) ? 16'((sy << 10) | (imm << 4) | ld)
                            : 16'((sy << 12) | (imm << 6) | (ld << 2));
              cyc(2'd0, 1'b1, 1'b0, {8'd0, c}, 1'b0, 1'b0, 1'b0);
              n++;
              wv = DW'(n * 40503 + 17);
              cyc(2'(ch + 1), 1'b1, 1'b1, wv, 1'b0, 1'b0, 1'b0);
              if (imm == 1) begin
                exp_act[ch] = wv;
                check("R2 immediate write", act_of(ch), exp_act[ch]);
                check("R2 immediate flag", {23'd0, full_o[ch]}, '0);
                cyc(2'd0, 1'b0, 1'b0, '0, ev == 0, ev == 1, ev == 2);
                check("R2 event ignored", act_of(ch), exp_act[ch]);
              end else begin
                check("R5 flag set", {23'd0, full_o[ch]}, 24'd1);
                check("R3 held before event", act_of(ch), exp_act[ch]);
                cyc(2'd0, 1'b0, 1'b0, '0, ev == 0, ev == 1, ev == 2);
                hit = exp_hit(ld, sy, ev);
                if (hit) exp_act[ch] = wv;
                if (sy == 0) check("R3 load decode", act_of(ch), exp_act[ch]);
                else         check("R4 sync decode", act_of(ch), exp_act[ch]);
                check("R6 flag after event", {23'd0, full_o[ch]}, {23'd0, !hit});
              end
            end

    // directed, channel A in shadow mode with zero load
    cyc(2'd0, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    cyc(2'd1, 1'b1, 1'b1, 24'h1234_56, 1'b0, 1'b0, 1'b0);
    cyc(2'd0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0);
    check("R3 zero load", act_of(0), 24'h123456);
    cyc(2'd1, 1'b0, 1'b1, 24'hFFFF_A5, 1'b0, 1'b0, 1'b0);
    check("R5 hr-only keeps flag", {23'd0, full_o[0]}, '0);
    rd(2'd1, v); check("R11 shadow readback", v, 24'h1234A5);
    check("R11 active untouched", act_of(0), 24'h123456);
    cyc(2'd0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0);
    check("R8 joint transfer", act_of(0), 24'h1234A5);
    cyc(2'd1, 1'b1, 1'b1, 24'h1111_11, 1'b0, 1'b0, 1'b0);
    cyc(2'd1, 1'b1, 1'b1, 24'h2222_22, 1'b0, 1'b0, 1'b0);
    check("R6 flag pending", {23'd0, full_o[0]}, 24'd1);
    cyc(2'd0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0);
    check("R6 last write wins", act_of(0), 24'h222222);
    check("R6 flag cleared", {23'd0, full_o[0]}, '0);
    cyc(2'd1, 1'b1, 1'b1, 24'h3333_33, 1'b1, 1'b0, 1'b0);
    check("R7 old shadow loaded", act_of(0), 24'h222222);
    check("R7 flag set", {23'd0, full_o[0]}, 24'd1);
    cyc(2'd0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0);
    check("R7 new value next load", act_of(0), 24'h333333);

    // R9 link, both channels immediate
    cyc(2'd0, 1'b1, 1'b0, 24'h008050, 1'b0, 1'b0, 1'b0);
    cyc(2'd1, 1'b1, 1'b1, 24'hAAAA_0F, 1'b0, 1'b0, 1'b0);
    cyc(2'd2, 1'b1, 1'b1, 24'hBBBB_F0, 1'b0, 1'b0, 1'b0);
    check("R9 linked hrb", {16'd0, hrb_o}, 24'h00000F);
    check("R9 cmpb unaffected", {8'd0, cmpb_o}, 24'h00BBBB);
    rd(2'd2, v); check("R11 immediate readback", v, 24'hBBBBF0);
    cyc(2'd0, 1'b1, 1'b0, 24'h000050, 1'b0, 1'b0, 1'b0);
    check("R9 unlinked hrb", {16'd0, hrb_o}, 24'h0000F0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule